// File: doc/BRIEF.md
# Pointer-Capable Register File

This block is the working register store of a small 8-bit RISC core. It holds thirty-two 8-bit registers. Two read ports are combinational and return bytes for the operand path. A third combinational view returns an aligned 16-bit register pair. One write port stores either a single byte or an aligned pair, and the store takes effect at the next clock edge.

The six highest registers double as three 16-bit address pointers, named X, Y and Z, and each pointer is presented on its own output. A pointer-update port takes a pointer and gives back the address to use this cycle. In the same cycle it writes the incremented or decremented pointer back. A side port maps the whole file into data addresses 0 to 31, so a load or store in that window reads or changes the register itself. The core drives decode, the ALU and the memory system around this block.

Top module: `ptr_regfile`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a rising edge) clears all 32 registers to zero.
- R2: A byte write (`wr_en`=1, `wr_pair`=0) stores `wr_data[7:0]` into register `wr_idx` at the next rising edge. `rd_a_data` and `rd_b_data` return registers `rd_a_idx` and `rd_b_idx` combinationally.
- R3: Reads show the value held before the edge during a cycle that writes the same register. There is no write-through.
- R4: A pair write (`wr_pair`=1) at even `wr_idx` stores `wr_data[7:0]` into register `wr_idx` and `wr_data[15:8]` into register `wr_idx`+1 in one edge.
- R5: A pair write at an odd `wr_idx` changes no register, and `pair_err` is high in that cycle. `pair_err` is also high when `rd_pair_req`=1 with an odd `rd_a_idx`.
- R6: `rd_pair_data` returns {register `rd_a_idx`+1, register `rd_a_idx`} for even `rd_a_idx`, and zero for odd `rd_a_idx`.
- R7: `ptr_x` = {R27,R26}, `ptr_y` = {R29,R28} and `ptr_z` = {R31,R30}; the odd register is the high byte.
- R8: With `ptr_en`=1 and `ptr_dec`=0, `ptr_addr` shows the selected pointer's current value, and the pointer becomes value+1 (mod 2^16) at the edge. `ptr_sel` encodes 0=X, 1=Y, 2=Z; with 3 no pointer changes and `ptr_addr` is zero. `ptr_addr` is zero whenever `ptr_en`=0.
- R9: With `ptr_en`=1 and `ptr_dec`=1, `ptr_addr` shows value-1 (mod 2^16), and the pointer becomes that value.
- R10: Per byte, the write priority is main write port, then memory-mapped write, then pointer update. A pointer byte not overwritten still takes its updated value.
- R11: For `mm_addr` < 0x20, `mm_hit` is 1 and `mm_rdata` returns register `mm_addr`. With `mm_we`=1, `mm_wdata` is stored into that register at the edge.
- R12: For `mm_addr` >= 0x20, `mm_hit` is 0, `mm_rdata` is zero, and a write there changes no register, even when the low five address bits alias a register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_a_idx | input | 5 | Read port A register index; also the base of the pair view |
| rd_b_idx | input | 5 | Read port B register index |
| rd_pair_req | input | 1 | Marks that the pair view is in use this cycle |
| rd_a_data | output | 8 | Register at rd_a_idx |
| rd_b_data | output | 8 | Register at rd_b_idx |
| rd_pair_data | output | 16 | Aligned pair at rd_a_idx, zero when odd |
| wr_en | input | 1 | Main write enable |
| wr_pair | input | 1 | 1 = 16-bit pair write, 0 = byte write |
| wr_idx | input | 5 | Main write register index |
| wr_data | input | 16 | Write data; low byte only for byte writes |
| pair_err | output | 1 | Odd index on a pair write or pair read |
| ptr_en | input | 1 | Request a pointer update |
| ptr_sel | input | 2 | 0=X, 1=Y, 2=Z, 3=none |
| ptr_dec | input | 1 | 0 = post-increment, 1 = pre-decrement |
| ptr_addr | output | 16 | Address produced by the pointer update |
| ptr_x | output | 16 | Pointer X {R27,R26} |
| ptr_y | output | 16 | Pointer Y {R29,R28} |
| ptr_z | output | 16 | Pointer Z {R31,R30} |
| mm_addr | input | 16 | Data-space address of a load or store |
| mm_we | input | 1 | Store enable for the mapped window |
| mm_wdata | input | 8 | Store data |
| mm_rdata | output | 8 | Load data, zero outside the window |
| mm_hit | output | 1 | Address lies in the register window |

## Verification
The bench moves pointers across a byte carry and wraps them below zero. A design that drops the carry would leave X at 0x0000 instead of 0x0100, and one that truncates would not reach 0xFFFF. It also writes a pointer byte from the main port and from the mapped port while the same pointer updates. A wrong priority would show the incremented byte where the written one belongs, or would lose the other half of the pointer. It writes to address 0x2C, which aliases register 12 in its low bits, so a decoder that ignores the upper bits would corrupt R12. Finally it checks odd pair requests: a design that rounds the index down would overwrite an even pair instead of leaving it alone.

// File: rtl/rf_pkg.sv
// Shared constants and the pointer selector encoding for the register file.
package rf_pkg;
    localparam int RF_REGS    = 32;  // number of byte registers
    localparam int RF_DW      = 8;   // register width
    localparam int RF_MAW     = 16;  // data-space address width
    localparam int RF_PTR_LO  = 26;  // first register used by the pointers
    localparam int RF_NPTR    = 3;   // pointer pairs above RF_PTR_LO
    localparam int RF_SELW    = 2;   // width of the pointer selector

    typedef enum logic [RF_SELW-1:0] {
        PTR_X    = 2'd0,
        PTR_Y    = 2'd1,
        PTR_Z    = 2'd2,
        PTR_NONE = 2'd3
    } ptr_sel_e;
endpackage

// File: rtl/rf_storage.sv
// Byte register array with a per-register write strobe.
// Assumes: strobes and data are already arbitrated; reset is synchronous active-low.
module rf_storage #(
    parameter int NREGS = rf_pkg::RF_REGS,
    parameter int DW    = rf_pkg::RF_DW
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NREGS-1:0]          we,
    input  logic [NREGS-1:0][DW-1:0]  wd,
    output logic [NREGS-1:0][DW-1:0]  q
);
    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        // Hold one register; clear on reset, load on its strobe.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[i] <= '0;
            else if (we[i])
                q[i] <= wd[i];
        end

        assert_reset_clears_R1: assert property (@(posedge clk)
            !rst_n |=> q[i] == '0)
            else $error("register %0d not cleared by reset", i);
    end
endmodule

// File: rtl/rf_ptr_unit.sv
// Selects one pointer pair, produces this cycle's address and the value
// to write back (post-increment or pre-decrement, modulo 2^PW).
// Assumes: selector codes at or above NPTR mean "no pointer".
module rf_ptr_unit #(
    parameter int DW   = rf_pkg::RF_DW,
    parameter int NPTR = rf_pkg::RF_NPTR,
    parameter int SELW = rf_pkg::RF_SELW
) (
    input  logic [NPTR-1:0][2*DW-1:0] ptr_val,
    input  logic                      upd_en,
    input  logic [SELW-1:0]           sel,
    input  logic                      dec,
    output logic                      upd_vld,
    output logic [SELW-1:0]           upd_sel,
    output logic [2*DW-1:0]           upd_val,
    output logic [2*DW-1:0]           addr
);
    localparam int PW = 2 * DW;

    logic [PW-1:0] cur;

    // Pick the selected pointer and compute its neighbour value.
    always_comb begin
        cur     = '0;
        upd_vld = 1'b0;
        for (int k = 0; k < NPTR; k++) begin
            if (upd_en && sel == SELW'(k)) begin
                cur     = ptr_val[k];
                upd_vld = 1'b1;
            end
        end
        upd_sel = sel;
        upd_val = dec ? cur - PW'(1) : cur + PW'(1);
        addr    = upd_vld ? (dec ? upd_val : cur) : '0;
    end
endmodule

// File: rtl/rf_wr_ctrl.sv
// Merges the main write port, the mapped-memory store and the pointer
// write-back into one strobe and byte per register.
// Priority per byte: main port, then mapped store, then pointer update.
// Assumes: pointers occupy 2*NPTR registers starting at PTR_LO, low byte even.
module rf_wr_ctrl #(
    parameter int NREGS  = rf_pkg::RF_REGS,
    parameter int DW     = rf_pkg::RF_DW,
    parameter int MAW    = rf_pkg::RF_MAW,
    parameter int PTR_LO = rf_pkg::RF_PTR_LO,
    parameter int NPTR   = rf_pkg::RF_NPTR,
    parameter int SELW   = rf_pkg::RF_SELW,
    localparam int IW    = $clog2(NREGS)
) (
    input  logic                      wr_en,
    input  logic                      wr_pair,
    input  logic [IW-1:0]             wr_idx,
    input  logic [2*DW-1:0]           wr_data,
    input  logic                      mm_we,
    input  logic [MAW-1:0]            mm_addr,
    input  logic [DW-1:0]             mm_wdata,
    input  logic                      upd_vld,
    input  logic [SELW-1:0]           upd_sel,
    input  logic [2*DW-1:0]           upd_val,
    output logic                      wr_pair_err,
    output logic [NREGS-1:0]          reg_we,
    output logic [NREGS-1:0][DW-1:0]  reg_wd
);
    logic              mm_in_win;
    logic [NREGS-1:0]  ptr_hit;
    logic [DW-1:0]     ptr_byte [NREGS];

    // Flag odd pair writes and decode the mapped window.
    always_comb begin
        wr_pair_err = wr_en && wr_pair && wr_idx[0];
        mm_in_win   = mm_addr < MAW'(NREGS);
    end

    for (genvar i = 0; i < NREGS; i++) begin : g_arb
        localparam logic [IW-1:0] MY = IW'(i);

        if (i >= PTR_LO && i < PTR_LO + 2 * NPTR) begin : g_ptr
            localparam int PK = (i - PTR_LO) / 2;
            localparam bit HI = ((i - PTR_LO) % 2) == 1;
            assign ptr_hit[i]  = upd_vld && (upd_sel == SELW'(PK));
            assign ptr_byte[i] = HI ? upd_val[2*DW-1:DW] : upd_val[DW-1:0];
        end else begin : g_plain
            assign ptr_hit[i]  = 1'b0;
            assign ptr_byte[i] = '0;
        end

        logic main_hit, mm_hit_i;
        logic [DW-1:0] main_byte;

        // Arbitrate the three write sources for this register.
        always_comb begin
            main_hit  = wr_en && !wr_pair_err &&
                        (wr_pair ? (wr_idx[IW-1:1] == MY[IW-1:1]) : (wr_idx == MY));
            main_byte = (wr_pair && MY[0]) ? wr_data[2*DW-1:DW] : wr_data[DW-1:0];
            mm_hit_i  = mm_we && mm_in_win && (mm_addr[IW-1:0] == MY);
            if (main_hit) begin
                reg_we[i] = 1'b1;
                reg_wd[i] = main_byte;
            end else if (mm_hit_i) begin
                reg_we[i] = 1'b1;
                reg_wd[i] = mm_wdata;
            end else if (ptr_hit[i]) begin
                reg_we[i] = 1'b1;
                reg_wd[i] = ptr_byte[i];
            end else begin
                reg_we[i] = 1'b0;
                reg_wd[i] = '0;
            end
        end
    end
endmodule

// File: rtl/ptr_regfile.sv
// Register file top: byte and pair reads, byte/pair writes, pointer views with
// post-increment / pre-decrement, and a data-space window onto every register.
// Assumes: synchronous active-low reset; all reads are combinational and
// return pre-edge contents (no bypass).
module ptr_regfile
    import rf_pkg::*;
#(
    parameter int NREGS  = RF_REGS,
    parameter int DW     = RF_DW,
    parameter int MAW    = RF_MAW,
    parameter int PTR_LO = RF_PTR_LO,
    localparam int IW    = $clog2(NREGS),
    localparam int PW    = 2 * DW
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [IW-1:0]   rd_a_idx,
    input  logic [IW-1:0]   rd_b_idx,
    input  logic            rd_pair_req,
    output logic [DW-1:0]   rd_a_data,
    output logic [DW-1:0]   rd_b_data,
    output logic [PW-1:0]   rd_pair_data,
    input  logic            wr_en,
    input  logic            wr_pair,
    input  logic [IW-1:0]   wr_idx,
    input  logic [PW-1:0]   wr_data,
    output logic            pair_err,
    input  logic            ptr_en,
    input  logic [1:0]      ptr_sel,
    input  logic            ptr_dec,
    output logic [PW-1:0]   ptr_addr,
    output logic [PW-1:0]   ptr_x,
    output logic [PW-1:0]   ptr_y,
    output logic [PW-1:0]   ptr_z,
    input  logic [MAW-1:0]  mm_addr,
    input  logic            mm_we,
    input  logic [DW-1:0]   mm_wdata,
    output logic [DW-1:0]   mm_rdata,
    output logic            mm_hit
);
    localparam int NPTR = RF_NPTR;

    logic [NREGS-1:0][DW-1:0] q;
    logic [NREGS-1:0][DW-1:0] reg_wd;
    logic [NREGS-1:0]         reg_we;
    logic [NPTR-1:0][PW-1:0]  ptr_val;
    logic                     upd_vld;
    logic [RF_SELW-1:0]       upd_sel;
    logic [PW-1:0]            upd_val;
    logic                     wr_pair_err;
    logic [IW-1:0]            pair_lo;
    logic [IW-1:0]            pair_hi;

    for (genvar k = 0; k < NPTR; k++) begin : g_view
        assign ptr_val[k] = {q[PTR_LO + 2*k + 1], q[PTR_LO + 2*k]};
    end

    // Expose the three pointer pairs.
    always_comb begin
        ptr_x = ptr_val[0];
        ptr_y = ptr_val[1];
        ptr_z = ptr_val[2];
    end

    // Combinational byte, pair and mapped reads plus error flag.
    always_comb begin
        pair_lo      = {rd_a_idx[IW-1:1], 1'b0};
        pair_hi      = {rd_a_idx[IW-1:1], 1'b1};
        rd_a_data    = q[rd_a_idx];
        rd_b_data    = q[rd_b_idx];
        rd_pair_data = rd_a_idx[0] ? '0 : {q[pair_hi], q[pair_lo]};
        pair_err     = wr_pair_err || (rd_pair_req && rd_a_idx[0]);
        mm_hit       = mm_addr < MAW'(NREGS);
        mm_rdata     = mm_hit ? q[mm_addr[IW-1:0]] : '0;
    end

    rf_ptr_unit #(.DW(DW), .NPTR(NPTR), .SELW(RF_SELW)) u_ptr (
        .ptr_val (ptr_val),
        .upd_en  (ptr_en),
        .sel     (ptr_sel),
        .dec     (ptr_dec),
        .upd_vld (upd_vld),
        .upd_sel (upd_sel),
        .upd_val (upd_val),
        .addr    (ptr_addr)
    );

    rf_wr_ctrl #(.NREGS(NREGS), .DW(DW), .MAW(MAW), .PTR_LO(PTR_LO),
                 .NPTR(NPTR), .SELW(RF_SELW)) u_wr (
        .wr_en       (wr_en),
        .wr_pair     (wr_pair),
        .wr_idx      (wr_idx),
        .wr_data     (wr_data),
        .mm_we       (mm_we),
        .mm_addr     (mm_addr),
        .mm_wdata    (mm_wdata),
        .upd_vld     (upd_vld),
        .upd_sel     (upd_sel),
        .upd_val     (upd_val),
        .wr_pair_err (wr_pair_err),
        .reg_we      (reg_we),
        .reg_wd      (reg_wd)
    );

    rf_storage #(.NREGS(NREGS), .DW(DW)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (reg_we),
        .wd    (reg_wd),
        .q     (q)
    );

    // Main byte write always lands (it has top priority).
    assert_byte_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_pair) |=> q[$past(wr_idx)] == $past(wr_data[DW-1:0]))
        else $error("byte write lost");

    // Even pair write lands in both bytes.
    assert_pair_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_pair && !wr_idx[0]) |=>
        {q[$past(wr_idx) | IW'(1)], q[$past(wr_idx)]} == $past(wr_data))
        else $error("pair write lost");

    // Odd pair write alone leaves the file untouched.
    assert_odd_pair_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_pair && wr_idx[0] && !mm_we && !ptr_en) |=> $stable(q))
        else $error("odd pair write modified the file");

    // Uncontested post-increment of X.
    assert_postinc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_en && ptr_sel == PTR_X && !ptr_dec && !wr_en && !mm_we) |=>
        ptr_x == $past(ptr_x) + PW'(1))
        else $error("X post-increment wrong");

    // Uncontested pre-decrement of Z ends at the presented address.
    assert_predec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_en && ptr_sel == PTR_Z && ptr_dec && !wr_en && !mm_we) |=>
        ptr_z == $past(ptr_addr))
        else $error("Z pre-decrement wrong");

    // Mapped store in the window reaches its register when the main port is idle.
    assert_mm_store_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_we && mm_hit && !wr_en) |=> q[$past(mm_addr[IW-1:0])] == $past(mm_wdata))
        else $error("mapped store lost");

    // Outside the window nothing is returned.
    assert_outside_window_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (mm_addr >= MAW'(NREGS)) |-> (!mm_hit && mm_rdata == '0))
        else $error("mapped read outside window returned data");
endmodule

// File: tb/ptr_regfile_tb.sv
`timescale 1ns/1ps
module ptr_regfile_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [4:0]  rd_a_idx, rd_b_idx, wr_idx;
    logic        rd_pair_req, wr_en, wr_pair, ptr_en, ptr_dec, mm_we;
    logic [1:0]  ptr_sel;
    logic [15:0] wr_data, mm_addr;
    logic [7:0]  mm_wdata;
    logic [7:0]  rd_a_data, rd_b_data, mm_rdata;
    logic [15:0] rd_pair_data, ptr_addr, ptr_x, ptr_y, ptr_z;
    logic        pair_err, mm_hit;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    ptr_regfile u_dut (
        .clk(clk), .rst_n(rst_n),
        .rd_a_idx(rd_a_idx), .rd_b_idx(rd_b_idx), .rd_pair_req(rd_pair_req),
        .rd_a_data(rd_a_data), .rd_b_data(rd_b_data), .rd_pair_data(rd_pair_data),
        .wr_en(wr_en), .wr_pair(wr_pair), .wr_idx(wr_idx), .wr_data(wr_data),
        .pair_err(pair_err),
        .ptr_en(ptr_en), .ptr_sel(ptr_sel), .ptr_dec(ptr_dec), .ptr_addr(ptr_addr),
        .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
        .mm_addr(mm_addr), .mm_we(mm_we), .mm_wdata(mm_wdata),
        .mm_rdata(mm_rdata), .mm_hit(mm_hit)
    );

    typedef struct packed {
        logic        wen;
        logic        pair;
        logic [4:0]  idx;
        logic [15:0] data;
        logic [4:0]  ra;
        logic [4:0]  rb;
        logic [7:0]  ea;
        logic [7:0]  eb;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 5'd0,  16'h0011, 5'd0,  5'd1,  8'h11, 8'h00},
        '{1'b1, 1'b0, 5'd31, 16'h00A5, 5'd31, 5'd0,  8'hA5, 8'h11},
        '{1'b1, 1'b1, 5'd4,  16'hBEEF, 5'd4,  5'd5,  8'hEF, 8'hBE},
        '{1'b1, 1'b1, 5'd7,  16'h1234, 5'd6,  5'd7,  8'h00, 8'h00},
        '{1'b1, 1'b0, 5'd5,  16'h003C, 5'd4,  5'd5,  8'hEF, 8'h3C},
        '{1'b1, 1'b1, 5'd30, 16'h0102, 5'd30, 5'd31, 8'h02, 8'h01},
        '{1'b0, 1'b0, 5'd0,  16'h0000, 5'd31, 5'd0,  8'h01, 8'h11},
        '{1'b1, 1'b1, 5'd0,  16'hFF00, 5'd0,  5'd1,  8'h00, 8'hFF}
    };

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle();
        wr_en = 0; wr_pair = 0; wr_idx = 0; wr_data = 0;
        ptr_en = 0; ptr_sel = 2'd3; ptr_dec = 0;
        mm_we = 0; mm_addr = 16'hFFFF; mm_wdata = 0; rd_pair_req = 0;
    endtask

    // drive at falling edge, let one rising edge pass, sample 1 ns later
    task automatic tick();
        @(posedge clk); #1;
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        rst_n = 0; rd_a_idx = 0; rd_b_idx = 0; idle();
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1;

        // R1: reset state
        for (int i = 0; i < 32; i++) begin
            rd_a_idx = 5'(i); #0.1;
            chk("R1 reset", {8'h00, rd_a_data}, 16'h0000);
        end

        // vector table: R2 byte writes, R4 pair writes, R5 odd pair
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            idle();
            wr_en = VECS[v].wen; wr_pair = VECS[v].pair;
            wr_idx = VECS[v].idx; wr_data = VECS[v].data;
            rd_a_idx = VECS[v].ra; rd_b_idx = VECS[v].rb;
            tick();
            chk(VECS[v].pair ? (VECS[v].idx[0] ? "R5 table" : "R4 table") : "R2 table",
                {rd_a_data, rd_b_data}, {VECS[v].ea, VECS[v].eb});
        end

        // R3: same-cycle read shows old value
        @(negedge clk); idle();
        wr_en = 1; wr_idx = 5'd10; wr_data = 16'h0077; rd_a_idx = 5'd10; #1;
        chk("R3 old value", {8'h00, rd_a_data}, 16'h0000);
        tick();
        chk("R3 new value", {8'h00, rd_a_data}, 16'h0077);

        // R6 / R5: pair read and odd flags
        @(negedge clk); idle();
        rd_pair_req = 1; rd_a_idx = 5'd4; #1;
        chk("R6 pair read", rd_pair_data, 16'h3CEF);
        chk("R5 even no err", {15'd0, pair_err}, 16'd0);
        rd_a_idx = 5'd7; #1;
        chk("R5 odd read err", {15'd0, pair_err}, 16'd1);
        chk("R6 odd read zero", rd_pair_data, 16'h0000);
        rd_pair_req = 0; wr_en = 1; wr_pair = 1; wr_idx = 5'd9; wr_data = 16'hCAFE;
        rd_a_idx = 5'd8; #1;
        chk("R5 odd write err", {15'd0, pair_err}, 16'd1);
        tick();
        chk("R5 odd write blocked", rd_pair_data, 16'h0000);

        // R7: pointer views
        @(negedge clk); idle();
        chk("R7 Z view", ptr_z, 16'h0102);
        wr_en = 1; wr_pair = 1; wr_idx = 5'd26; wr_data = 16'h00FF; tick();
        chk("R7 X view", ptr_x, 16'h00FF);
        @(negedge clk); wr_idx = 5'd28; wr_data = 16'hABCD; tick();
        chk("R7 Y view", ptr_y, 16'hABCD);

        // R8: post-increment with byte carry
        @(negedge clk); idle();
        ptr_en = 1; ptr_sel = 2'd0; ptr_dec = 0; #1;
        chk("R8 addr", ptr_addr, 16'h00FF);
        tick();
        chk("R8 X incremented", ptr_x, 16'h0100);

        // R9: pre-decrement, including wrap below zero
        @(negedge clk); ptr_sel = 2'd1; ptr_dec = 1; #1;
        chk("R9 addr", ptr_addr, 16'hABCC);
        tick();
        chk("R9 Y decremented", ptr_y, 16'hABCC);
        @(negedge clk); idle();
        wr_en = 1; wr_pair = 1; wr_idx = 5'd28; wr_data = 16'h0000; tick();
        @(negedge clk); idle(); ptr_en = 1; ptr_sel = 2'd1; ptr_dec = 1; #1;
        chk("R9 wrap addr", ptr_addr, 16'hFFFF);
        tick();
        chk("R9 wrap value", ptr_y, 16'hFFFF);

        // R10: main write beats pointer update; mapped store beats pointer update
        @(negedge clk); idle();
        ptr_en = 1; ptr_sel = 2'd0; ptr_dec = 0;
        wr_en = 1; wr_idx = 5'd26; wr_data = 16'h0055; tick();
        chk("R10 main over ptr", ptr_x, 16'h0155);
        @(negedge clk); idle();
        ptr_en = 1; ptr_sel = 2'd2; ptr_dec = 1;
        mm_we = 1; mm_addr = 16'h001F; mm_wdata = 8'hEE; tick();
        chk("R10 mapped over ptr", ptr_z, 16'hEE01);

        // R11: mapped window store and load
        @(negedge clk); idle();
        mm_we = 1; mm_addr = 16'h000C; mm_wdata = 8'h5A; rd_a_idx = 5'd12; #1;
        chk("R11 hit", {15'd0, mm_hit}, 16'd1);
        tick();
        chk("R11 store", {8'h00, rd_a_data}, 16'h005A);
        @(negedge clk); idle(); mm_addr = 16'h001F; #1;
        chk("R11 load", {7'd0, mm_hit, mm_rdata}, 16'h01EE);

        // R12: outside the window
        @(negedge clk); idle();
        mm_we = 1; mm_addr = 16'h002C; mm_wdata = 8'h99; rd_a_idx = 5'd12; #1;
        chk("R12 no hit", {15'd0, mm_hit}, 16'd0);
        tick();
        chk("R12 alias untouched", {8'h00, rd_a_data}, 16'h005A);
        @(negedge clk); idle(); mm_addr = 16'h0020; #1;
        chk("R12 load 0x20", {7'd0, mm_hit, mm_rdata}, 16'h0000);
        mm_addr = 16'h100C; #1;
        chk("R12 load high", {7'd0, mm_hit, mm_rdata}, 16'h0000);

        // R8: selector 3 updates nothing
        @(negedge clk); idle(); ptr_en = 1; ptr_sel = 2'd3; #1;
        chk("R8 none addr", ptr_addr, 16'h0000);
        tick();
        chk("R8 none stable", ptr_x ^ ptr_y ^ ptr_z, 16'h0155 ^ 16'hFFFF ^ 16'hEE01);

        // R1: reset after traffic
        @(negedge clk); idle(); rst_n = 0; tick();
        @(negedge clk); rst_n = 1;
        for (int i = 0; i < 32; i++) begin
            rd_a_idx = 5'(i); #0.1;
            chk("R1 re-reset", {8'h00, rd_a_data}, 16'h0000);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule